// File: doc/BRIEF.md
# Memory-to-memory DMA channel engine

This block is a compact DMA controller that moves data between memory buffers on behalf of up to 32 channels. Each channel's description lives in a table in ordinary memory. The table starts at an address that software programs, and each channel owns a 16-byte slot in it. Software writes the source and destination end pointers and a control word into the slot. It then sets the channel's enable bit and its software-request bit. The engine arbitrates, fetches the slot, runs the read/write beat loop, and writes the control word back to the table.

Both pointers name the last byte of the transfer, inclusive. The engine therefore derives every beat address by stepping backwards from the end pointer by the remaining item count. The item count is stored minus one. A channel releases the engine after every 2^N beats, where N comes from the control word. When it releases, it records its progress in the table and competes again. When a transfer finishes, the engine clears the channel's enable bit, writes the mode field back as stopped, and raises a one-cycle interrupt if the channel's mask bit allows it.

A single-beat memory master serves both the table accesses and the data beats. The register slave is a plain write-strobe port with a combinational read path.

Top module: `mdma_engine`

## Requirements
- R1: After reset every register reads zero, `mem_req` is low and `done_irq` is low. The register map uses word index `reg_addr`: 0 is the table base (read/write), 1 sets enable bits (write one to set, reads the enable vector), 2 clears enable bits (write one to clear, reads the enable vector), 3 sets software requests (write one to set, reads the pending vector), and 4 is the interrupt mask (read/write, bit c for channel c).
- R2: On grant the engine reads three words at base + 16·c + 0, + 4 and + 8, in that order. These are the source end pointer, the destination end pointer and the control word.
- R3: A beat address is end pointer − rem·step. Here rem is the remaining count minus one, and step is 1, 2 or 4 bytes for increment code 0, 1 or 2. Increment code 3 keeps the address fixed at the end pointer. Source increment is control bits [27:26] and destination increment is bits [31:30].
- R4: A transfer moves control[13:4] + 1 items. Each item is one read from the source followed by one write to the destination. The source size is bits [25:24] and the destination size is bits [29:28], with code 0 for byte, 1 for halfword and 2 for word. `mem_size` carries the code. Data is right-justified on the bus and zero-extended.
- R5: Let N be control[17:14]. If N is below 10, after 2^N beats in one grant the engine writes the control word back to +8. The written word has bits [13:4] set to the new remaining-minus-one value and every other bit unchanged. The channel's request is then re-posted and arbitration runs again. If N is 10 or more, the engine never pauses.
- R6: Among channels with both enable and request set, the lowest channel number is granted first.
- R7: On the last beat the engine writes the control word back with bits [13:4] and [2:0] set to zero and every other bit unchanged, and then clears the channel's enable bit.
- R8: A completed transfer pulses `done_irq` high for exactly one cycle when the channel's mask bit is set. There is no pulse when the mask bit is clear.
- R9: A software request for a channel whose enable bit is clear is discarded. It does not read back as pending, and a later enable does not start a transfer from it.
- R10: If the fetched control word has a mode field [2:0] other than 2 (auto), or a size field equal to 3, the engine clears the channel's enable bit. It then performs no data beat and no write-back, and raises no interrupt.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_we`, `mem_addr`, `mem_size` and `mem_wdata` stay unchanged. An access completes in the cycle `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size code: 0 byte, 1 halfword, 2 word |
| mem_wdata | output | 32 | Right-justified write data |
| mem_rdata | input | 32 | Right-justified read data, valid with ack |
| mem_ack | input | 1 | Access completion |
| done_irq | output | 1 | One-cycle transfer-completion pulse |

## Verification
The hardest case to reach from the ports is a channel that pauses at an arbitration boundary while another request is still pending. Reaching it requires the written-back count, the re-posted request and the lowest-number rule to interact within the same few cycles. The stimulus enables two channels with one-beat arbitration and raises both requests in a single register write. In this state each pause re-posts the lower channel, which must win again before the higher one ever starts. A non-incrementing halfword destination with a two-beat pause, and control words that must be rejected, cover the remaining edges of the address and abort paths.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FSRC,
        ST_FDST,
        ST_FCTL,
        ST_READ,
        ST_WRITE,
        ST_WBACK
    } st_e;

    localparam logic [2:0] MODE_AUTO  = 3'd2;
    localparam logic [1:0] SIZE_BAD   = 2'd3;
    localparam logic [3:0] ARB_NEVER  = 4'd10;

    // Right-justify and zero-extend an item of the given size code.
    function automatic logic [31:0] fit_item(input logic [31:0] d, input logic [1:0] sz);
        case (sz)
            2'd0:    fit_item = {24'd0, d[7:0]};
            2'd1:    fit_item = {16'd0, d[15:0]};
            default: fit_item = d;
        endcase
    endfunction

endpackage

// File: rtl/mdma_regs.sv
module mdma_regs #(
    parameter int NCH = 32,
    parameter int AW  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [NCH-1:0]   grant_vec,
    input  logic [NCH-1:0]   repend_vec,
    input  logic [NCH-1:0]   finish_vec,
    output logic [NCH-1:0]   en_o,
    output logic [NCH-1:0]   req_o,
    output logic [NCH-1:0]   mask_o,
    output logic [AW-1:0]    base_o
);

    typedef struct packed {
        logic [NCH-1:0] en;
        logic [NCH-1:0] req;
        logic [NCH-1:0] mask;
        logic [AW-1:0]  base;
    } regs_t;

    regs_t q, d;
    logic [NCH-1:0] wv;

    assign wv = reg_wdata[NCH-1:0];

    always_comb begin
        d = q;
        // engine side first, software writes take precedence
        d.req = (d.req & ~grant_vec) | (repend_vec & d.en);
        d.en  = d.en & ~finish_vec;
        if (reg_we) begin
            case (reg_addr)
                3'd0: d.base = reg_wdata[AW-1:0];
                3'd1: d.en   = d.en | wv;
                3'd2: d.en   = d.en & ~wv;
                3'd3: d.req  = d.req | (wv & d.en);
                3'd4: d.mask = wv;
                default: ;
            endcase
        end
        d.req = d.req & d.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            3'd0:       reg_rdata = 32'(q.base);
            3'd1, 3'd2: reg_rdata = 32'(q.en);
            3'd3:       reg_rdata = 32'(q.req);
            3'd4:       reg_rdata = 32'(q.mask);
            default:    reg_rdata = '0;
        endcase
    end

    assign en_o   = q.en;
    assign req_o  = q.req;
    assign mask_o = q.mask;
    assign base_o = q.base;

    // R9: a pending request never survives without its enable bit
    a_r9_req_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (q.req & ~q.en) == '0);

endmodule

// File: rtl/mdma_arb.sv
module mdma_arb #(
    parameter int NCH = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  pend,
    output logic            gnt_any,
    output logic [CW-1:0]   gnt_idx,
    output logic [NCH-1:0]  gnt_vec
);

    localparam logic [NCH-1:0] ONE = NCH'(1);

    always_comb begin
        gnt_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) gnt_idx = CW'(i);
        end
        gnt_any = |pend;
        gnt_vec = gnt_any ? (ONE << gnt_idx) : '0;
    end

    // R6: one winner at most, and only from the pending set
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_vec));
    a_r6_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_vec & ~pend) == '0);

endmodule

// File: rtl/mdma_addr.sv
module mdma_addr #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] end_ptr,
    input  logic [9:0]    rem,
    input  logic [1:0]    inc,
    output logic [AW-1:0] addr
);

    always_comb begin
        if (inc == 2'd3) addr = end_ptr;
        else             addr = end_ptr - (AW'(rem) << inc);
    end

endmodule

// File: rtl/mdma_core.sv
module mdma_core
    import mdma_pkg::*;
#(
    parameter int NCH = 32,
    parameter int AW  = 32,
    parameter int CW  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   base,
    input  logic [NCH-1:0]  mask,
    input  logic            gnt_any,
    input  logic [CW-1:0]   gnt_idx,
    output logic            take,
    output logic [NCH-1:0]  repend_vec,
    output logic [NCH-1:0]  finish_vec,
    output logic [AW-1:0]   src_end,
    output logic [AW-1:0]   dst_end,
    output logic [9:0]      rem,
    output logic [1:0]      src_inc,
    output logic [1:0]      dst_inc,
    input  logic [AW-1:0]   src_addr,
    input  logic [AW-1:0]   dst_addr,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    output logic            done_irq
);

    localparam logic [NCH-1:0] ONE = NCH'(1);

    typedef struct packed {
        st_e            st;
        logic [CW-1:0]  ch;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [31:0]    ctl;
        logic [9:0]     rem;
        logic [10:0]    cnt;
        logic [31:0]    data;
        logic           last;
        logic           irq;
    } core_t;

    core_t q, d;
    logic [AW-1:0] slot;
    logic          bad_ctl;

    assign slot    = base + AW'({q.ch, 4'h0});
    assign bad_ctl = (mem_rdata[2:0] != MODE_AUTO) || (mem_rdata[25:24] == SIZE_BAD)
                     || (mem_rdata[29:28] == SIZE_BAD);

    always_comb begin
        d          = q;
        d.irq      = 1'b0;
        take       = 1'b0;
        repend_vec = '0;
        finish_vec = '0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_size   = 2'd2;
        mem_wdata  = '0;
        case (q.st)
            ST_IDLE: begin
                if (gnt_any) begin
                    take = 1'b1;
                    d.ch = gnt_idx;
                    d.st = ST_FSRC;
                end
            end
            ST_FSRC: begin
                mem_req  = 1'b1;
                mem_addr = slot;
                if (mem_ack) begin
                    d.src = mem_rdata[AW-1:0];
                    d.st  = ST_FDST;
                end
            end
            ST_FDST: begin
                mem_req  = 1'b1;
                mem_addr = slot + AW'(4);
                if (mem_ack) begin
                    d.dst = mem_rdata[AW-1:0];
                    d.st  = ST_FCTL;
                end
            end
            ST_FCTL: begin
                mem_req  = 1'b1;
                mem_addr = slot + AW'(8);
                if (mem_ack) begin
                    d.ctl = mem_rdata;
                    d.rem = mem_rdata[13:4];
                    d.cnt = '0;
                    if (bad_ctl) begin
                        finish_vec = ONE << q.ch;
                        d.st       = ST_IDLE;
                    end else begin
                        d.st = ST_READ;
                    end
                end
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_addr;
                mem_size = q.ctl[25:24];
                if (mem_ack) begin
                    d.data = fit_item(mem_rdata, q.ctl[25:24]);
                    d.st   = ST_WRITE;
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_addr;
                mem_size  = q.ctl[29:28];
                mem_wdata = fit_item(q.data, q.ctl[29:28]);
                if (mem_ack) begin
                    if (q.rem == '0) begin
                        d.ctl  = {q.ctl[31:14], 10'd0, q.ctl[3], 3'd0};
                        d.last = 1'b1;
                        d.st   = ST_WBACK;
                    end else begin
                        d.rem = q.rem - 10'd1;
                        d.cnt = q.cnt + 11'd1;
                        if (q.ctl[17:14] < ARB_NEVER && d.cnt == (11'd1 << q.ctl[17:14])) begin
                            d.ctl[13:4] = d.rem;
                            d.last      = 1'b0;
                            d.st        = ST_WBACK;
                        end else begin
                            d.st = ST_READ;
                        end
                    end
                end
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = slot + AW'(8);
                mem_wdata = q.ctl;
                if (mem_ack) begin
                    if (q.last) begin
                        finish_vec = ONE << q.ch;
                        d.irq      = mask[q.ch];
                    end else begin
                        repend_vec = ONE << q.ch;
                    end
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src_end  = q.src;
    assign dst_end  = q.dst;
    assign rem      = q.rem;
    assign src_inc  = q.ctl[27:26];
    assign dst_inc  = q.ctl[31:30];
    assign done_irq = q.irq;

    // R11: a waiting access holds all of its attributes
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_size) && $stable(mem_wdata)));
    // R8: completion interrupt lasts a single cycle
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
    // R10: data beats only run on an accepted control word
    a_r10_valid_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_READ) |-> (q.ctl[2:0] == MODE_AUTO && q.ctl[25:24] != SIZE_BAD));
    // R7: the final write-back carries a stopped mode and zero count
    a_r7_stop_word: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WBACK && q.last) |-> (mem_wdata[2:0] == 3'd0 && mem_wdata[13:4] == 10'd0));

endmodule

// File: rtl/mdma_engine.sv
module mdma_engine #(
    parameter int NCH = 32,
    parameter int AW  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [1:0]    mem_size,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    output logic          done_irq
);

    localparam int CW = $clog2(NCH);

    logic [NCH-1:0] en, req, mask, gnt_vec, repend_vec, finish_vec;
    logic [AW-1:0]  base, src_end, dst_end, src_addr, dst_addr;
    logic           gnt_any, take;
    logic [CW-1:0]  gnt_idx;
    logic [9:0]     rem;
    logic [1:0]     src_inc, dst_inc;

    mdma_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .grant_vec(take ? gnt_vec : '0), .repend_vec(repend_vec), .finish_vec(finish_vec),
        .en_o(en), .req_o(req), .mask_o(mask), .base_o(base)
    );

    mdma_arb #(.NCH(NCH), .CW(CW)) u_arb (
        .clk(clk), .rst_n(rst_n), .pend(en & req),
        .gnt_any(gnt_any), .gnt_idx(gnt_idx), .gnt_vec(gnt_vec)
    );

    mdma_addr #(.AW(AW)) u_src_addr (
        .end_ptr(src_end), .rem(rem), .inc(src_inc), .addr(src_addr)
    );

    mdma_addr #(.AW(AW)) u_dst_addr (
        .end_ptr(dst_end), .rem(rem), .inc(dst_inc), .addr(dst_addr)
    );

    mdma_core #(.NCH(NCH), .AW(AW), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .base(base), .mask(mask),
        .gnt_any(gnt_any), .gnt_idx(gnt_idx), .take(take),
        .repend_vec(repend_vec), .finish_vec(finish_vec),
        .src_end(src_end), .dst_end(dst_end), .rem(rem),
        .src_inc(src_inc), .dst_inc(dst_inc),
        .src_addr(src_addr), .dst_addr(dst_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done_irq(done_irq)
    );

endmodule

// File: tb/mdma_engine_bench.sv
module mdma_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, done_irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #4 clk = ~clk;

    mdma_engine u_mdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .done_irq(done_irq)
    );

    localparam int BASE = 32'h800;

    logic [7:0] mem    [0:4095];
    logic [7:0] shadow [0:4095];

    typedef struct {
        bit          we;
        int          addr;
        int          size;
        logic [31:0] wd;
        string       tag;
    } acc_t;

    acc_t exp_q[$];
    int n_cmp = 0, n_bad = 0, n_irq = 0, exp_irq = 0;
    logic [31:0] irq_mask_tb = 32'hFFFF_FFEF;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // memory slave: ack one cycle after a request, lanes right-justified
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata[7:0];
                if (mem_size >= 2'd1) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
                if (mem_size == 2'd2) begin
                    mem[mem_addr[11:0] + 12'd2] <= mem_wdata[23:16];
                    mem[mem_addr[11:0] + 12'd3] <= mem_wdata[31:24];
                end
            end else begin
                case (mem_size)
                    2'd0:    mem_rdata <= {24'd0, mem[mem_addr[11:0]]};
                    2'd1:    mem_rdata <= {16'd0, mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
                    default: mem_rdata <= {mem[mem_addr[11:0] + 12'd3], mem[mem_addr[11:0] + 12'd2],
                                           mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]};
                endcase
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // every clock: compare completed accesses against the model queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_irq) n_irq++;
            if (mem_req && mem_ack) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9", "unexpected access addr", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    acc_t e;
                    e = exp_q.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr && mem_size == e.size[1:0],
                        e.tag, "access we/size/addr", {mem_we, 1'b0, mem_size, mem_addr[27:0]},
                        {e.we, 1'b0, e.size[1:0], e.addr[27:0]});
                    if (e.we) chk(mem_wdata == e.wd, e.tag, "write data", mem_wdata, e.wd);
                end
            end
        end
    end

    function automatic logic [31:0] sh_rd(input int a, input int sz);
        case (sz)
            0:       return {24'd0, shadow[a]};
            1:       return {16'd0, shadow[a+1], shadow[a]};
            default: return {shadow[a+3], shadow[a+2], shadow[a+1], shadow[a]};
        endcase
    endfunction

    task automatic sh_wr(input int a, input int sz, input logic [31:0] v);
        shadow[a] = v[7:0];
        if (sz >= 1) shadow[a+1] = v[15:8];
        if (sz == 2) begin shadow[a+2] = v[23:16]; shadow[a+3] = v[31:24]; end
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        for (int i = 0; i < 4; i++) begin
            mem[a+i]    = v[8*i +: 8];
            shadow[a+i] = v[8*i +: 8];
        end
    endtask

    function automatic logic [31:0] mkctl(input int dinc, input int dsz, input int sinc,
                                          input int ssz, input int arb, input int nm1,
                                          input int mode);
        return {dinc[1:0], dsz[1:0], sinc[1:0], ssz[1:0], 6'd0, arb[3:0], nm1[9:0], 1'b0, mode[2:0]};
    endfunction

    function automatic logic [31:0] fit(input logic [31:0] v, input int sz);
        if (sz == 0) return v & 32'hFF;
        if (sz == 1) return v & 32'hFFFF;
        return v;
    endfunction

    task automatic push(input bit we, input int a, input int sz, input logic [31:0] wd,
                        input string tag);
        acc_t e;
        e.we = we; e.addr = a; e.size = sz; e.wd = wd; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // behavioural model of one channel's transfer, from its table slot
    task automatic model_xfer(input int ch);
        int slot, se, de, rem, cnt, arb, sinc, dinc, ssz, dsz, sa, da;
        logic [31:0] ctl, item;
        bit fin;
        slot = BASE + ch * 16;
        fin  = 0;
        while (!fin) begin
            push(0, slot,     2, 0, "R2");
            push(0, slot + 4, 2, 0, "R2");
            push(0, slot + 8, 2, 0, "R2");
            se  = sh_rd(slot, 2);
            de  = sh_rd(slot + 4, 2);
            ctl = sh_rd(slot + 8, 2);
            if (ctl[2:0] != 3'd2 || ctl[25:24] == 2'd3 || ctl[29:28] == 2'd3) return;
            rem = ctl[13:4]; arb = ctl[17:14];
            sinc = ctl[27:26]; dinc = ctl[31:30]; ssz = ctl[25:24]; dsz = ctl[29:28];
            cnt = 0;
            forever begin
                sa = (sinc == 3) ? se : se - rem * (1 << sinc);
                da = (dinc == 3) ? de : de - rem * (1 << dinc);
                push(0, sa, ssz, 0, "R3");
                item = fit(sh_rd(sa, ssz), dsz);
                push(1, da, dsz, item, "R4");
                sh_wr(da, dsz, item);
                if (rem == 0) begin
                    ctl[13:4] = 10'd0; ctl[2:0] = 3'd0;
                    push(1, slot + 8, 2, ctl, "R7");
                    sh_wr(slot + 8, 2, ctl);
                    if (irq_mask_tb[ch]) exp_irq++;
                    fin = 1;
                    break;
                end
                rem--; cnt++;
                if (arb < 10 && cnt == (1 << arb)) begin
                    ctl[13:4] = rem[9:0];
                    push(1, slot + 8, 2, ctl, "R5");
                    sh_wr(slot + 8, 2, ctl);
                    break;
                end
            end
        end
    endtask

    task automatic reg_write(input int a, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a[2:0]; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a[2:0];
        #1 v = reg_rdata;
    endtask

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (12) @(negedge clk);
    endtask

    task automatic cmp_region(input int a, input int n, input string req);
        logic [31:0] am, as;
        am = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
        as = {shadow[a+3], shadow[a+2], shadow[a+1], shadow[a]};
        for (int i = 0; i < n; i++)
            if ({mem[a+4*i+3], mem[a+4*i+2], mem[a+4*i+1], mem[a+4*i]} !=
                {shadow[a+4*i+3], shadow[a+4*i+2], shadow[a+4*i+1], shadow[a+4*i]}) begin
                am = {mem[a+4*i+3], mem[a+4*i+2], mem[a+4*i+1], mem[a+4*i]};
                as = {shadow[a+4*i+3], shadow[a+4*i+2], shadow[a+4*i+1], shadow[a+4*i]};
            end
        chk(am == as, req, "memory contents", am, as);
    endtask

    task automatic set_slot(input int ch, input int se, input int de, input logic [31:0] ctl);
        put_word(BASE + ch * 16,     se);
        put_word(BASE + ch * 16 + 4, de);
        put_word(BASE + ch * 16 + 8, ctl);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'(i * 37 + 11);
            shadow[i] = mem[i];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < 5; r++) begin
            reg_read(r, v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end
        chk(mem_req == 0 && done_irq == 0, "R1", "req/irq after reset",
            {30'd0, mem_req, done_irq}, 0);

        reg_write(0, BASE);
        reg_read(0, v);
        chk(v == BASE, "R1", "base readback", v, BASE);
        reg_write(4, irq_mask_tb);

        // word copy on channel 30 with a pause every 8 beats (R2 R3 R4 R5 R7 R8)
        set_slot(30, 32'h13C, 32'h23C, mkctl(2, 2, 2, 2, 3, 15, 2));
        model_xfer(30);
        reg_write(1, 32'h4000_0000);
        reg_write(3, 32'h4000_0000);
        drain();
        chk(exp_q.size() == 0, "R5", "accesses left over", exp_q.size(), 0);
        cmp_region(32'h200, 16, "R4");
        cmp_region(BASE + 30 * 16 + 8, 1, "R7");
        reg_read(1, v);
        chk(v[30] == 0, "R7", "enable self-clear", v, 0);
        chk(n_irq == exp_irq, "R8", "irq pulse count", n_irq, exp_irq);

        // byte copy, never pausing (R3 R4 R5)
        set_slot(3, 32'h304, 32'h384, mkctl(0, 0, 0, 0, 12, 4, 2));
        model_xfer(3);
        reg_write(1, 32'h8);
        reg_write(3, 32'h8);
        drain();
        cmp_region(32'h380, 2, "R4");
        cmp_region(BASE + 3 * 16 + 8, 1, "R7");

        // halfword into a fixed destination, pause every 2 beats (R3 R5)
        set_slot(7, 32'h506, 32'h600, mkctl(3, 1, 1, 1, 1, 3, 2));
        model_xfer(7);
        reg_write(1, 32'h80);
        reg_write(3, 32'h80);
        drain();
        cmp_region(32'h600, 1, "R3");
        chk(n_irq == exp_irq, "R8", "irq pulse count", n_irq, exp_irq);

        // two channels, one write, one-beat pauses: lower runs first (R6, R8 masked on 4)
        set_slot(2, 32'h708, 32'h788, mkctl(2, 2, 2, 2, 0, 2, 2));
        set_slot(4, 32'h808 - 32'h100, 32'h7C8, mkctl(2, 2, 2, 2, 0, 2, 2));
        model_xfer(2);
        model_xfer(4);
        reg_write(1, 32'h14);
        reg_write(3, 32'h14);
        drain();
        chk(exp_q.size() == 0, "R6", "accesses left over", exp_q.size(), 0);
        cmp_region(32'h780, 3, "R6");
        cmp_region(32'h7C0, 3, "R6");
        reg_read(1, v);
        chk(v[4] == 0 && v[2] == 0, "R7", "both enables cleared", v, 0);
        chk(n_irq == exp_irq, "R8", "masked channel gives no pulse", n_irq, exp_irq);

        // request on a disabled channel (R9)
        set_slot(9, 32'h1C, 32'h3C, mkctl(2, 2, 2, 2, 10, 1, 2));
        reg_write(3, 32'h200);
        reg_read(3, v);
        chk(v == 0, "R9", "request on disabled channel pending", v, 0);
        reg_write(1, 32'h200);
        repeat (30) @(negedge clk);
        chk(mem_req == 0, "R9", "no activity after late enable", mem_req, 0);
        reg_read(3, v);
        chk(v == 0, "R9", "still nothing pending", v, 0);
        reg_write(2, 32'h200);

        // rejected control words (R10)
        set_slot(12, 32'h11C, 32'h9C, mkctl(2, 2, 2, 2, 10, 1, 0));
        set_slot(13, 32'h11C, 32'h9C, mkctl(2, 2, 2, 3, 10, 1, 2));
        model_xfer(12);
        model_xfer(13);
        reg_write(1, 32'h3000);
        reg_write(3, 32'h3000);
        drain();
        chk(exp_q.size() == 0, "R10", "accesses left over", exp_q.size(), 0);
        reg_read(1, v);
        chk(v[13:12] == 0, "R10", "enable cleared on bad word", v, 0);
        cmp_region(BASE + 12 * 16 + 8, 1, "R10");
        cmp_region(BASE + 13 * 16 + 8, 1, "R10");
        cmp_region(32'h90, 4, "R10");
        chk(n_irq == exp_irq, "R10", "no irq on rejected word", n_irq, exp_irq);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule